// File: doc/BRIEF.md
# Serial Controller Register File

This block is the bus-facing register and status logic of a serial controller with a receive FIFO. A processor reaches it over a simple byte-wide bus with a one-cycle write strobe and a one-cycle read strobe. Read data is registered and appears one cycle after the read strobe. Received bytes arrive on a strobe from a deserializer and are stored in a 16-entry circular FIFO. Bytes written to the transmit data register leave as a one-cycle output strobe toward a serializer.

Status is kept as five sticky flags. Software clears a flag by writing zero to its bit. Writing one leaves the flag as it is. A programmable trigger level decides when the receive-threshold flag and the receive interrupt assert. The transmit-ready flags are modelled without a real shifter: they come back whenever status is read while transmission is enabled.

Register offsets:
- mode 0x00
- control 0x08
- transmit data 0x0c
- status 0x10
- receive data 0x14
- FIFO control 0x18
- port 0x20

Control bits:
- bit 4: receive enable
- bit 5: transmit enable
- bit 6: receive interrupt enable
- bit 7: transmit interrupt

Status bits:
- bit 6: transmit end
- bit 5: transmit data empty
- bit 4: break
- bit 1: receive threshold
- bit 0: data ready

Top module: `serial_regfile`

## Requirements
- R1: After reset, status reads 0x60, control reads 0x20, mode, port and FIFO control read 0x00, both interrupts are low and the transmit strobe is low.
- R2: Writes are masked before they are stored: mode with 0x7b, control with 0xfa, port with 0xf3. A read of any offset that is not mapped returns 0x00.
- R3: A received byte is stored only while control bit 4 is 1. Storing a byte sets status bit 0. A byte that arrives while bit 4 is 0 is ignored.
- R4: The receive FIFO holds 16 bytes and returns them in arrival order across index wrap. A byte that arrives while 16 are held is dropped.
- R5: FIFO control bits 7:6 select the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. These bits read back at the same positions. After a store, status bit 1 sets if the count is at or above the trigger level.
- R6: A read of offset 0x14 pops the oldest byte. Status bit 1 clears if the remaining count falls below the trigger level. A read of an empty FIFO returns 0x00 and changes nothing.
- R7: The receive interrupt rises only on a store that leaves the count at or above the trigger level while control bit 6 is 1.
- R8: The receive interrupt drops on a status write with bit 1 or bit 0 equal to 0. It also drops on a control write with bit 6 equal to 0.
- R9: On a status write, each of bits 6, 5, 4, 1 and 0 clears where the written bit is 0 and is unchanged where it is 1.
- R10: A write to offset 0x0c emits the byte on the transmit strobe for exactly one cycle, in the cycle after the write. It also clears status bit 5.
- R11: A status read returns the flags as they were before the read. If control bit 5 is 1, the read then sets bits 5 and 6. A control write with bit 5 equal to 0 sets bit 6.
- R12: The transmit interrupt output follows control bit 7.
- R13: A one-cycle break pulse sets status bit 4.
- R14: A FIFO control write with bit 1 set empties the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset inside the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break event pulse |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The FIFO is driven with short bursts under a trigger level of 4, where the threshold flag rises on the fourth byte and falls on the first pop. It is also driven with a burst of seventeen bytes that starts from a non-zero index; this separates correct wrap and drop from an off-by-one count. A burst against a trigger level of 14 shows whether the interrupt follows the level rather than any store. Status writes with single zero bits, mixed with reads under both transmit-enable settings, separate write-zero-to-clear from plain overwrite, and separate the read side effect from the returned value.

// File: rtl/serial_regfile.sv
module serial_regfile #(
  parameter int DEPTH = 16,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_break,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          rx_irq,
  output logic          tx_irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [AW-1:0] OFS_MODE = AW'(8'h00);
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h08);
  localparam logic [AW-1:0] OFS_TXD  = AW'(8'h0c);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h10);
  localparam logic [AW-1:0] OFS_RXD  = AW'(8'h14);
  localparam logic [AW-1:0] OFS_FCR  = AW'(8'h18);
  localparam logic [AW-1:0] OFS_PORT = AW'(8'h20);

  logic [7:0]    mode_q, ctrl_q, port_q;
  logic [1:0]    trig_q;
  logic          tend_q, tde_q, brk_q, rdf_q, dr_q;
  logic          tend_d, tde_d, brk_d, rdf_d, dr_d;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q, count_d, thr;

  wire wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
  wire wr_txd  = bus_wr && bus_addr == OFS_TXD;
  wire wr_stat = bus_wr && bus_addr == OFS_STAT;
  wire wr_fcr  = bus_wr && bus_addr == OFS_FCR;
  wire rd_stat = bus_rd && bus_addr == OFS_STAT;
  wire rd_rxd  = bus_rd && bus_addr == OFS_RXD;

  wire fifo_clr = wr_fcr && bus_wdata[1];
  wire push     = rx_valid && ctrl_q[4] && count_q != CW'(DEPTH) && !fifo_clr;
  wire pop      = rd_rxd && count_q != '0 && !fifo_clr;

  wire [7:0] stat_val = {1'b0, tend_q, tde_q, brk_q, 2'b00, rdf_q, dr_q};

  assign tx_irq = ctrl_q[7];

  always_comb begin
    case (trig_q)
      2'd0:    thr = CW'(1);
      2'd1:    thr = CW'(4);
      2'd2:    thr = CW'(8);
      default: thr = CW'(14);
    endcase
  end

  always_comb begin
    if (fifo_clr) count_d = '0;
    else          count_d = count_q + CW'(push) - CW'(pop);
  end

  always_comb begin
    tend_d = tend_q;
    tde_d  = tde_q;
    brk_d  = brk_q;
    rdf_d  = rdf_q;
    dr_d   = dr_q;
    if (wr_stat) begin
      tend_d = tend_q & bus_wdata[6];
      tde_d  = tde_q  & bus_wdata[5];
      brk_d  = brk_q  & bus_wdata[4];
      rdf_d  = rdf_q  & bus_wdata[1];
      dr_d   = dr_q   & bus_wdata[0];
    end
    if (wr_ctrl && !bus_wdata[5]) tend_d = 1'b1;
    if (wr_txd) tde_d = 1'b0;
    if (rd_stat && ctrl_q[5]) begin
      tde_d  = 1'b1;
      tend_d = 1'b1;
    end
    if (pop && count_d < thr) rdf_d = 1'b0;
    if (push) begin
      dr_d = 1'b1;
      if (count_d >= thr) rdf_d = 1'b1;
    end
    if (rx_break) brk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= 8'h20;
      port_q <= '0;
      trig_q <= '0;
      tend_q <= 1'b1;
      tde_q  <= 1'b1;
      brk_q  <= 1'b0;
      rdf_q  <= 1'b0;
      dr_q   <= 1'b0;
    end else begin
      tend_q <= tend_d;
      tde_q  <= tde_d;
      brk_q  <= brk_d;
      rdf_q  <= rdf_d;
      dr_q   <= dr_d;
      if (bus_wr) begin
        case (bus_addr)
          OFS_MODE: mode_q <= bus_wdata & 8'h7b;
          OFS_CTRL: ctrl_q <= bus_wdata & 8'hfa;
          OFS_PORT: port_q <= bus_wdata & 8'hf3;
          OFS_FCR:  trig_q <= bus_wdata[7:6];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      count_q <= count_d;
      if (fifo_clr) begin
        head_q <= '0;
        tail_q <= '0;
      end else begin
        if (push) head_q <= (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
        if (pop)  tail_q <= (tail_q == PW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[head_q] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else if (push && count_d >= thr && ctrl_q[6]) rx_irq <= 1'b1;
    else if ((wr_stat && !(bus_wdata[1] && bus_wdata[0])) ||
             (wr_ctrl && !bus_wdata[6])) rx_irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr_txd;
      if (wr_txd) tx_data <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        OFS_MODE: bus_rdata <= mode_q;
        OFS_CTRL: bus_rdata <= ctrl_q;
        OFS_STAT: bus_rdata <= stat_val;
        OFS_RXD:  bus_rdata <= (count_q != '0) ? mem[tail_q] : 8'h00;
        OFS_FCR:  bus_rdata <= {trig_q, 6'b0};
        OFS_PORT: bus_rdata <= port_q;
        default:  bus_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/serial_regfile_chk.sv
module serial_regfile_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [AW-1:0]           bus_addr,
  input logic [7:0]              bus_wdata,
  input logic                    rx_valid,
  input logic                    tx_valid,
  input logic [7:0]              tx_data,
  input logic                    rx_irq,
  input logic                    tx_irq,
  input logic [$clog2(DEPTH):0]  count_q
);
  localparam int CW = $clog2(DEPTH) + 1;
  wire rd_rx    = bus_rd && bus_addr == AW'(8'h14);
  wire fcr_clr  = bus_wr && bus_addr == AW'(8'h18) && bus_wdata[1];

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(DEPTH) && rx_valid && !rd_rx && !fcr_clr) |=> count_q == CW'(DEPTH));

  assert_tx_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h0c)) |=> (tx_valid && tx_data == $past(bus_wdata)));

  assert_tx_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h08)) |=> tx_irq == $past(bus_wdata[7]));

  assert_rx_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(rx_valid));

  assert_rx_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h10) && !bus_wdata[0] && !rx_valid) |=> !rx_irq);
endmodule

bind serial_regfile serial_regfile_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
  .tx_valid(tx_valid), .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq),
  .count_q(count_q)
);

// File: tb/tb_serial_regfile.sv
`timescale 1ns/1ps
module tb_serial_regfile;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [5:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic rx_valid = 0, rx_break = 0;
  logic [7:0] rx_data = 0;
  logic tx_valid, rx_irq, tx_irq;
  logic [7:0] tx_data;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [5:0] A_MODE = 6'h00, A_CTRL = 6'h08, A_TXD = 6'h0c,
    A_STAT = 6'h10, A_RXD = 6'h14, A_FCR = 6'h18, A_PORT = 6'h20;

  always #2 clk = ~clk;

  serial_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irqs/strobe", {rx_irq, tx_irq, tx_valid}, 0);
    rd(A_STAT, v); check("R1 status", v, 8'h60);
    rd(A_CTRL, v); check("R1 control", v, 8'h20);
    rd(A_MODE, v); check("R1 mode", v, 0);
    rd(A_FCR, v);  check("R1 fifo ctrl", v, 0);
    rd(A_PORT, v); check("R1 port", v, 0);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr(A_MODE, 8'hff); rd(A_MODE, v); check("R2 mode mask", v, 8'h7b);
    wr(A_CTRL, 8'hff); rd(A_CTRL, v); check("R2 ctrl mask", v, 8'hfa);
    check("R12 tx_irq set", tx_irq, 1);
    wr(A_PORT, 8'hff); rd(A_PORT, v); check("R2 port mask", v, 8'hf3);
    rd(6'h04, v); check("R2 unmapped 0x04", v, 0);
    rd(6'h24, v); check("R2 unmapped 0x24", v, 0);
    wr(A_CTRL, 8'h20); check("R12 tx_irq clear", tx_irq, 0);
  endtask

  task automatic t_rx_disabled();
    logic [7:0] v;
    wr(A_STAT, 8'h00);
    push(8'haa);
    rd(A_STAT, v); check("R3 disabled no data-ready", v, 8'h00);
    rd(A_RXD, v);  check("R3 disabled nothing stored", v, 0);
  endtask

  task automatic t_order_trig4();
    logic [7:0] v;
    wr(A_CTRL, 8'h30); wr(A_FCR, 8'h40); wr(A_STAT, 8'h00);
    push(8'h11); push(8'h22); push(8'h33);
    rd(A_STAT, v); check("R5 below level 4", v & 8'h03, 8'h01);
    push(8'h44);
    rd(A_STAT, v); check("R5 reach level 4", v & 8'h03, 8'h03);
    rd(A_RXD, v);  check("R6 pop first", v, 8'h11);
    rd(A_STAT, v); check("R6 threshold clears", v & 8'h03, 8'h01);
    rd(A_RXD, v);  check("R4 order 2", v, 8'h22);
    rd(A_RXD, v);  check("R4 order 3", v, 8'h33);
    rd(A_RXD, v);  check("R4 order 4", v, 8'h44);
    rd(A_RXD, v);  check("R6 empty read", v, 0);
    rd(A_FCR, v);  check("R5 trigger readback", v, 8'h40);
    check("R7 no irq while disabled", rx_irq, 0);
  endtask

  task automatic t_full_wrap();
    logic [7:0] v;
    wr(A_FCR, 8'h00);
    for (int i = 1; i <= 16; i++) push(8'(i));
    push(8'hee);
    for (int i = 1; i <= 16; i++) begin
      rd(A_RXD, v); check("R4 wrap order", v, i);
    end
    rd(A_RXD, v); check("R4 overflow byte dropped", v, 0);
  endtask

  task automatic t_trig14_irq();
    logic [7:0] v;
    wr(A_CTRL, 8'h70); wr(A_FCR, 8'hc0); wr(A_STAT, 8'h00);
    for (int i = 0; i < 13; i++) push(8'(8'h80 + i));
    check("R7 no irq below 14", rx_irq, 0);
    rd(A_STAT, v); check("R5 below level 14", v & 8'h02, 0);
    push(8'h8d);
    check("R7 irq at 14", rx_irq, 1);
    wr(A_STAT, 8'hfe);
    check("R8 status bit0 zero drops irq", rx_irq, 0);
    rd(A_STAT, v); check("R9 bit1 kept, bit0 cleared", v & 8'h03, 8'h02);
    push(8'h8e);
    check("R7 irq again at 15", rx_irq, 1);
    wr(A_CTRL, 8'h30);
    check("R8 ctrl bit6 zero drops irq", rx_irq, 0);
    wr(A_FCR, 8'h02);
    rd(A_RXD, v); check("R14 fifo reset empties", v, 0);
  endtask

  task automatic t_break_clear();
    logic [7:0] v;
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); check("R9 all cleared", v, 8'h00);
    @(negedge clk); rx_break = 1; @(negedge clk); rx_break = 0;
    rd(A_STAT, v); check("R13 break sets bit4", v, 8'h70);
    wr(A_STAT, 8'hef);
    rd(A_STAT, v); check("R9 clear only bit4", v, 8'h60);
    wr(A_STAT, 8'hbf);
    rd(A_STAT, v); check("R9 clear only bit6", v, 8'h20);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    wr(A_CTRL, 8'h10);
    wr(A_TXD, 8'h5a);
    check("R10 strobe high", tx_valid, 1);
    check("R10 strobe byte", tx_data, 8'h5a);
    @(negedge clk); check("R10 strobe one cycle", tx_valid, 0);
    rd(A_STAT, v); check("R10/R11 tde clear, tend set", v & 8'h60, 8'h40);
    rd(A_STAT, v); check("R11 no reassert when tx off", v & 8'h60, 8'h40);
    wr(A_CTRL, 8'h30);
    rd(A_STAT, v); check("R11 read returns old flags", v & 8'h60, 8'h40);
    rd(A_STAT, v); check("R11 reasserted after read", v & 8'h60, 8'h60);
  endtask

  task automatic t_fifo_reset();
    logic [7:0] v;
    push(8'h01); push(8'h02);
    wr(A_FCR, 8'h02);
    rd(A_RXD, v); check("R14 reset drops held bytes", v, 0);
    push(8'h77);
    rd(A_RXD, v); check("R14 fifo usable after reset", v, 8'h77);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_rx_disabled();
    t_order_trig4();
    t_full_wrap();
    t_trig14_irq();
    t_break_clear();
    t_tx();
    t_fifo_reset();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule